// File: doc/BRIEF.md
# Controller Output Port with A20 Gate and Reset Request

This block keeps the eight-bit output port of a keyboard-controller style peripheral and drives two system signals from it: the A20 address gate and a CPU reset request. The port changes in three ways: a full-byte write from the controller's pending-write path, two gate commands that force bit 1 high or low, and a pulse command group that can ask for a reset. A read command returns the current port byte as a one-cycle reply. Bits 4 and 5 of the port are not stored. They show live copies of the keyboard and auxiliary buffer-full flags that come from the status logic.

Bit 0 of the port is an active-low reset line. A reset request is a pulse on `rst_req` whose width is set by the parameter `PULSE_CYC`, counted in clock cycles. A new trigger while a pulse is running reloads the count, so the pulse becomes longer and does not break into two.

Top module: `outport_ctrl`

## Requirements
- R1: After reset the stored port is 0xCF, so `port_val` reads 0xCF with bits 4 and 5 taken from the flags. `a20_gate` is 1, and `rst_req` and `reply_valid` are 0.
- R2: A full write (`wr_en`) stores bits 7:6 and 3:0 of `wr_data` one cycle later. Written bits 5:4 are ignored. `port_val[4]` always equals `kbd_full` and `port_val[5]` always equals `aux_full`.
- R3: After a full write, `a20_gate` equals bit 1 of the written byte from the next cycle on.
- R4: Command 0xDF sets port bit 1 and `a20_gate`. Command 0xDD clears both. Neither changes any other port bit.
- R5: Command 0xD0 raises `reply_valid` for exactly one cycle, in the next cycle, and `reply_data` then carries the `port_val` of the command cycle. No other input raises `reply_valid`.
- R6: A full write whose bit 0 is 0 raises `rst_req` in the next cycle. A write whose bit 0 is 1 starts no pulse.
- R7: A command whose upper nibble is 0xF starts a reset pulse when its bit 0 is 0 and has no effect when its bit 0 is 1. Neither case changes the port byte.
- R8: A single trigger holds `rst_req` high for exactly `PULSE_CYC` cycles, starting in the cycle after the trigger.
- R9: A trigger during an active pulse reloads the count, so `rst_req` stays high without a gap until `PULSE_CYC` cycles after the last trigger.
- R10: Any command code not named in R4, R5 or R7 leaves `port_val`, `a20_gate`, `rst_req` and `reply_valid` unchanged.
- R11: When a write and a command arrive in the same cycle, the write is applied first and a gate command then overrides bit 1. A read command in that cycle replies with the port value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Full-byte port write strobe |
| wr_data | input | 8 | Byte to load into the port |
| cmd_valid | input | 1 | Controller command strobe |
| cmd_code | input | 8 | Controller command byte |
| kbd_full | input | 1 | Keyboard output-buffer-full flag |
| aux_full | input | 1 | Auxiliary output-buffer-full flag |
| port_val | output | 8 | Current output port value |
| a20_gate | output | 1 | A20 gate level (port bit 1) |
| rst_req | output | 1 | Active-high CPU reset request pulse |
| reply_valid | output | 1 | Read-port reply strobe |
| reply_data | output | 8 | Reply byte |

## Verification
The bench writes all 256 byte values and issues all 256 command codes, so each code in the pulse group is covered. A decoder that tests only 0xFE, or that ignores bit 0 in the group, starts reset pulses on the wrong codes. A port that stores written bits 5:4 shows stale flags instead of the live ones. For pulse length, the bench checks that `rst_req` is still high in the last cycle of the window and low in the cycle after it, which catches a counter that is off by one. A retrigger in the middle of a pulse must give one longer pulse, and a design that ignores the retrigger drops `rst_req` too early. Same-cycle write and command pairs check that a gate command overrides the written bit 1 and that a read replies with the value from before the write.

// File: rtl/outport_pkg.sv
package outport_pkg;

  localparam logic [7:0] PORT_RST_VAL = 8'hCF;
  localparam logic [7:0] CMD_GATE_ON  = 8'hDF;
  localparam logic [7:0] CMD_GATE_OFF = 8'hDD;
  localparam logic [7:0] CMD_PORT_RD  = 8'hD0;
  localparam logic [3:0] PULSE_GROUP  = 4'hF;
  localparam int         GATE_BIT     = 1;
  localparam int         RSTN_BIT     = 0;
  localparam int         KBD_FLAG_BIT = 4;
  localparam int         AUX_FLAG_BIT = 5;

  typedef struct packed {
    logic gate_on;
    logic gate_off;
    logic port_rd;
    logic pulse_rst;
  } cmd_dec_t;

  function automatic cmd_dec_t decode_cmd(input logic [7:0] code);
    cmd_dec_t d;
    d.gate_on   = (code == CMD_GATE_ON);
    d.gate_off  = (code == CMD_GATE_OFF);
    d.port_rd   = (code == CMD_PORT_RD);
    d.pulse_rst = (code[7:4] == PULSE_GROUP) && !code[RSTN_BIT];
    return d;
  endfunction

  function automatic logic byte_asks_reset(input logic [7:0] b);
    return !b[RSTN_BIT];
  endfunction

  function automatic logic is_flag_bit(input int idx);
    return (idx == KBD_FLAG_BIT) || (idx == AUX_FLAG_BIT);
  endfunction

  function automatic logic [7:0] merge_flags(input logic [7:0] held,
                                             input logic kf, input logic af);
    logic [7:0] m;
    m = held;
    m[KBD_FLAG_BIT] = kf;
    m[AUX_FLAG_BIT] = af;
    return m;
  endfunction

endpackage

// File: rtl/outport_cmd_dec.sv
module outport_cmd_dec
  import outport_pkg::*;
(
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  output logic       gate_on,
  output logic       gate_off,
  output logic       port_rd,
  output logic       rst_trig
);
  cmd_dec_t dec;

  always_comb begin
    dec      = decode_cmd(cmd_code);
    gate_on  = cmd_valid && dec.gate_on;
    gate_off = cmd_valid && dec.gate_off;
    port_rd  = cmd_valid && dec.port_rd;
    rst_trig = (wr_en && byte_asks_reset(wr_data)) ||
               (cmd_valid && dec.pulse_rst);
  end
endmodule

// File: rtl/outport_reg.sv
module outport_reg
  import outport_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             gate_on,
  input  logic             gate_off,
  output logic [WIDTH-1:0] held
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (is_flag_bit(i)) begin : g_flag
      assign held[i] = 1'b0;
    end else if (i == GATE_BIT) begin : g_gate
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        held[i] <= PORT_RST_VAL[i];
        else if (gate_on)  held[i] <= 1'b1;
        else if (gate_off) held[i] <= 1'b0;
        else if (wr_en)    held[i] <= wr_data[i];
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     held[i] <= PORT_RST_VAL[i];
        else if (wr_en) held[i] <= wr_data[i];
      end
    end
  end

  AST_GATE_ON_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on |=> held[GATE_BIT]); // R4
  AST_GATE_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    gate_off && !gate_on |=> !held[GATE_BIT]); // R4
endmodule

// File: rtl/outport_rst_pulse.sv
module outport_rst_pulse #(
  parameter int PULSE_CYC = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic rst_req
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_CYC);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (trig)           remain <= LOAD_VAL;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign rst_req = (remain != '0);

  AST_TRIG_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> rst_req); // R6
  AST_NO_END_AFTER_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> !$past(trig)); // R9
  AST_REQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(trig)); // R8
endmodule

// File: rtl/outport_ctrl.sv
module outport_ctrl
  import outport_pkg::*;
#(
  parameter int PULSE_CYC = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  input  logic       kbd_full,
  input  logic       aux_full,
  output logic [7:0] port_val,
  output logic       a20_gate,
  output logic       rst_req,
  output logic       reply_valid,
  output logic [7:0] reply_data
);
  logic       gate_on, gate_off, port_rd, rst_trig;
  logic [7:0] held;

  outport_cmd_dec u_dec (
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .cmd_valid(cmd_valid),
    .cmd_code (cmd_code),
    .gate_on  (gate_on),
    .gate_off (gate_off),
    .port_rd  (port_rd),
    .rst_trig (rst_trig)
  );

  outport_reg #(.WIDTH(8)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .gate_on (gate_on),
    .gate_off(gate_off),
    .held    (held)
  );

  outport_rst_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig   (rst_trig),
    .rst_req(rst_req)
  );

  assign port_val = merge_flags(held, kbd_full, aux_full);
  assign a20_gate = held[GATE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reply_valid <= 1'b0;
      reply_data  <= '0;
    end else begin
      reply_valid <= port_rd;
      if (port_rd) reply_data <= port_val;
    end
  end

  AST_READ_REPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == CMD_PORT_RD |=>
      reply_valid && reply_data == $past(port_val)); // R5
  AST_REPLY_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    reply_valid |-> $past(cmd_valid && cmd_code == CMD_PORT_RD)); // R5
  AST_WRITE_DRIVES_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !(cmd_valid && (cmd_code == CMD_GATE_ON || cmd_code == CMD_GATE_OFF))
      |=> a20_gate == $past(wr_data[GATE_BIT])); // R3
  AST_PLAIN_WRITE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[RSTN_BIT] && !cmd_valid && !rst_req |=> !rst_req); // R6
endmodule

// File: tb/outport_ctrl_tb_top.sv
module outport_ctrl_tb_top;
  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_code = '0;
  logic       kbd_full = 1'b0;
  logic       aux_full = 1'b0;
  logic [7:0] port_val;
  logic       a20_gate, rst_req, reply_valid;
  logic [7:0] reply_data;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  outport_ctrl #(.PULSE_CYC(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .kbd_full(kbd_full), .aux_full(aux_full),
    .port_val(port_val), .a20_gate(a20_gate), .rst_req(rst_req),
    .reply_valid(reply_valid), .reply_data(reply_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [7:0] wd,
                       input logic ce, input logic [7:0] cd);
    @(negedge clk);
    wr_en = we; wr_data = wd; cmd_valid = ce; cmd_code = cd;
    @(posedge clk);
    #1;
    wr_en = 1'b0; cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] expect_port(input logic [7:0] stored,
                                             input logic kf, input logic af);
    return (stored & 8'hCF) + (kf ? 8'h10 : 8'h00) + (af ? 8'h20 : 8'h00);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] base, exp_st;
    logic       exp_rst, exp_rep;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R1 port", port_val, 8'hCF);
    chk("R1 a20", a20_gate, 1);
    chk("R1 rst_req", rst_req, 0);
    chk("R1 reply_valid", reply_valid, 0);

    for (int v = 0; v < 256; v++) begin
      kbd_full = v[3];
      aux_full = v[6];
      drive(1'b1, 8'(v), 1'b0, 8'h00);
      chk("R2 port after write", port_val, expect_port(8'(v), v[3], v[6]));
      chk("R3 a20 after write", a20_gate, v[1]);
      chk("R6 rst_req after write", rst_req, !v[0]);
      chk("R10 no reply on write", reply_valid, 0);
      if (!v[0]) begin
        idle(P - 1);
        chk("R8 pulse still high at end", rst_req, 1);
        idle(1);
        chk("R8 pulse ends", rst_req, 0);
      end else begin
        idle(P);
        chk("R6 no pulse", rst_req, 0);
      end
    end

    for (int c = 0; c < 256; c++) begin
      kbd_full = c[2];
      aux_full = c[5];
      base = c[1] ? 8'hCB : 8'h79;
      drive(1'b1, base, 1'b0, 8'h00);
      idle(P + 1);
      exp_st  = (c == 8'hDF) ? (base | 8'h02) :
                (c == 8'hDD) ? (base & 8'hFD) : base;
      exp_rst = (c[7:4] == 4'hF) && !c[0];
      exp_rep = (c == 8'hD0);
      drive(1'b0, 8'h00, 1'b1, 8'(c));
      chk("R4 R7 R10 port after cmd", port_val, expect_port(exp_st, c[2], c[5]));
      chk("R4 R10 a20 after cmd", a20_gate, exp_st[1]);
      chk("R7 R10 rst_req after cmd", rst_req, exp_rst);
      chk("R5 R10 reply_valid", reply_valid, exp_rep);
      if (exp_rep) begin
        chk("R5 reply data", reply_data, expect_port(base, c[2], c[5]));
        idle(1);
        chk("R5 reply one cycle", reply_valid, 0);
      end
      idle(P + 1);
    end

    kbd_full = 1'b0; aux_full = 1'b0;
    drive(1'b1, 8'h00, 1'b0, 8'h00);
    idle(2);
    chk("R9 pulse mid", rst_req, 1);
    drive(1'b0, 8'h00, 1'b1, 8'hFE);
    idle(P - 1);
    chk("R9 extended pulse still high", rst_req, 1);
    idle(1);
    chk("R9 extended pulse ends", rst_req, 0);
    chk("R7 port kept bit0 low", port_val, 8'h00);

    drive(1'b1, 8'hC9, 1'b1, 8'hDF);
    chk("R11 gate on overrides write", port_val, 8'hCB);
    chk("R11 a20 on", a20_gate, 1);
    drive(1'b1, 8'h0B, 1'b1, 8'hDD);
    chk("R11 gate off overrides write", port_val, 8'h09);
    chk("R11 a20 off", a20_gate, 0);
    drive(1'b1, 8'hCB, 1'b1, 8'hD0);
    chk("R11 read sees old value", reply_data, 8'h09);
    chk("R11 write applied", port_val, 8'hCB);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule